// File: doc/BRIEF.md
# Transmit Character Multiplexer (4:1)

This block turns a wide word arriving on a slow clock into a stream of narrow characters on a fast clock. The fast clock runs at four times the slow rate. On every rising edge of the slow clock the block takes four data bytes. Each byte comes with two control bits: one marks the byte as a special (comma or control) character, and the other asks the downstream encoder to force negative running disparity. The block then drives one 10-bit character per fast-clock period. Each character holds the byte together with its own two flags.

The two clocks are phase-related. Every slow rising edge coincides with a fast rising edge. The slow side holds each word in a short pipeline. The fast side watches a toggle bit that flips on every slow edge, and uses it to realign a small phase counter. That counter steps through the latched bytes, so the output latency is fixed and repeatable. The output is registered on the fast rising edge. It is therefore steady around the fast falling edge, where a serializer downstream picks it up.

Top module: `tx_char_mux`

## Requirements
- R1: Each output character carries the byte in bits 7:0, the byte's special flag in bit 8 and its force-negative-disparity flag in bit 9.
- R2: Bytes leave most significant first: lane 3 (`tx_data[31:24]`, `tx_special[3]`, `tx_neg[3]`) first, then lane 2 and lane 1, and lane 0 (`tx_data[7:0]`) last.
- R3: Take a word captured on a slow rising edge. Counting that edge as fast edge 0, character i of the word (i = 0 first) appears on `char_out` just after fast rising edge 13+i and stays there for one fast period.
- R4: Consecutive words leave back to back, one character per fast period, with no gaps or repeats.
- R5: While `rst_n` is low at a fast rising edge, `char_out` is zero after that edge. After reset the output stays zero until the first captured word reaches it.
- R6: A reset asserted mid-stream discards every word in flight. The block restarts correctly whatever the slow-clock phase at which reset is released.
- R7: The fast side picks up exactly one new word per slow period. It does so on the fast edge right after each slow edge, and its phase counter then restarts at 1.
- R8: Input changes between slow rising edges have no effect: only the values present at a slow rising edge reach the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_fast | input | 1 | Character clock, four times the slow rate |
| clk_slow | input | 1 | Word clock, rising edges aligned with fast rising edges |
| rst_n | input | 1 | Synchronous active-low reset, seen by both clock domains |
| tx_data | input | 32 | Four bytes, lane 3 in bits 31:24 down to lane 0 in bits 7:0 |
| tx_special | input | 4 | Per-lane special-character flag |
| tx_neg | input | 4 | Per-lane force-negative-disparity flag |
| char_out | output | 10 | Outgoing character: {neg flag, special flag, byte} |

## Verification
The hardest case to reach from the ports is a reset release at each of the four fast-clock offsets within a slow period, with words still in flight inside the pipeline. The first word after release must still come out at exactly the fixed latency. To reach this, the stimulus asserts reset mid-stream several times and releases it each time at a different fast offset. Between slow edges it also drives garbage onto the inputs and restores them before the next slow edge, so any leak of off-edge values shows up in the character stream.

// File: rtl/tx_mux_pkg.sv
// Shared constants and the character type for the transmit multiplexer.
// Assumes a character is one byte plus two control flags.
package tx_mux_pkg;
    localparam int BYTE_W = 8;
    localparam int CHAR_W = BYTE_W + 2;

    typedef struct packed {
        logic              neg_disp;
        logic              special;
        logic [BYTE_W-1:0] data;
    } char_t;
endpackage

// File: rtl/tx_mux_slow_pipe.sv
// Slow-domain capture and delay line.
// Bundles each lane's byte with its flags, captures the word on the slow
// rising edge and delays it through STAGES registers (the capture included).
// Also flips a toggle bit on every slow edge, which the fast domain uses
// to find the slow-clock phase.
// Assumes STAGES >= 1 and that rst_n is synchronous to the slow clock.
module tx_mux_slow_pipe
    import tx_mux_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int STAGES = 4
) (
    input  logic                      clk_slow,
    input  logic                      rst_n,
    input  logic [LANES*BYTE_W-1:0]   data_i,
    input  logic [LANES-1:0]          special_i,
    input  logic [LANES-1:0]          neg_i,
    output char_t [LANES-1:0]         word_o,
    output logic                      tog_o
);
    char_t [LANES-1:0] cap;
    char_t [LANES-1:0] stg [STAGES];

    // Pair each lane's byte with its two flags.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign cap[l] = {neg_i[l], special_i[l], data_i[l*BYTE_W +: BYTE_W]};
    end

    // Capture and shift the word; flip the phase toggle on every slow edge.
    always_ff @(posedge clk_slow) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stg[s] <= '0;
            tog_o <= 1'b0;
        end else begin
            stg[0] <= cap;
            for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
            tog_o <= ~tog_o;
        end
    end

    assign word_o = stg[STAGES-1];
endmodule

// File: rtl/tx_mux_phase_ctl.sv
// Fast-domain phase tracker.
// Detects each flip of the slow-domain toggle and raises load_o for one
// fast cycle, on the fast edge right after each slow edge. A phase counter
// restarts at 1 after each load and gives the index of the next character.
// Assumes LANES is a power of two, at least 2, and that the clocks are
// phase-related with rising edges aligned.
module tx_mux_phase_ctl #(
    parameter int LANES = 4,
    localparam int PH_W = $clog2(LANES)
) (
    input  logic            clk_fast,
    input  logic            rst_n,
    input  logic            tog_i,
    output logic            load_o,
    output logic [PH_W-1:0] phase_o
);
    logic tog_q;

    assign load_o = tog_i ^ tog_q;

    // Keep the last toggle value seen, so that a flip can be detected.
    always_ff @(posedge clk_fast) begin
        if (!rst_n) tog_q <= 1'b0;
        else        tog_q <= tog_i;
    end

    // Restart the phase on a load; otherwise step to the next character.
    always_ff @(posedge clk_fast) begin
        if (!rst_n)      phase_o <= '0;
        else if (load_o) phase_o <= PH_W'(1);
        else             phase_o <= phase_o + 1'b1;
    end
endmodule

// File: rtl/tx_mux_char_sel.sv
// Fast-domain shadow register and output selector.
// On a load it latches the whole word and sends its most significant lane
// at once. On the other fast cycles it sends the lane that the phase
// counter selects, working down toward lane 0.
// Assumes load_i and phase_i come from tx_mux_phase_ctl.
module tx_mux_char_sel
    import tx_mux_pkg::*;
#(
    parameter int LANES = 4,
    localparam int PH_W = $clog2(LANES)
) (
    input  logic              clk_fast,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [PH_W-1:0]   phase_i,
    input  char_t [LANES-1:0] word_i,
    output char_t             char_o
);
    localparam logic [PH_W-1:0] TOP_LANE = PH_W'(LANES - 1);

    char_t [LANES-1:0] shadow;

    // Latch the word on a load and register the selected character.
    always_ff @(posedge clk_fast) begin
        if (!rst_n) begin
            shadow <= '0;
            char_o <= '0;
        end else if (load_i) begin
            shadow <= word_i;
            char_o <= word_i[TOP_LANE];
        end else begin
            char_o <= shadow[TOP_LANE - phase_i];
        end
    end
endmodule

// File: rtl/tx_char_mux.sv
// Top level of the 4:1 transmit character multiplexer.
// Takes LANES bytes plus flags on the slow clock and sends one character per
// fast clock, most significant lane first. The latency is fixed by STAGES.
// Assumes clk_fast runs at LANES times clk_slow with aligned rising edges,
// and that rst_n is held low across at least one slow rising edge.
module tx_char_mux
    import tx_mux_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int STAGES = 4,
    localparam int PH_W  = $clog2(LANES)
) (
    input  logic                    clk_fast,
    input  logic                    clk_slow,
    input  logic                    rst_n,
    input  logic [LANES*BYTE_W-1:0] tx_data,
    input  logic [LANES-1:0]        tx_special,
    input  logic [LANES-1:0]        tx_neg,
    output logic [CHAR_W-1:0]       char_out
);
    char_t [LANES-1:0] word;
    char_t             out_char;
    logic              tog;
    logic              load;
    logic [PH_W-1:0]   phase;

    tx_mux_slow_pipe #(.LANES(LANES), .STAGES(STAGES)) u_pipe (
        .clk_slow  (clk_slow),
        .rst_n     (rst_n),
        .data_i    (tx_data),
        .special_i (tx_special),
        .neg_i     (tx_neg),
        .word_o    (word),
        .tog_o     (tog)
    );

    tx_mux_phase_ctl #(.LANES(LANES)) u_phase (
        .clk_fast (clk_fast),
        .rst_n    (rst_n),
        .tog_i    (tog),
        .load_o   (load),
        .phase_o  (phase)
    );

    tx_mux_char_sel #(.LANES(LANES)) u_sel (
        .clk_fast (clk_fast),
        .rst_n    (rst_n),
        .load_i   (load),
        .phase_i  (phase),
        .word_i   (word),
        .char_o   (out_char)
    );

    assign char_out = out_char;
endmodule

// File: rtl/tx_char_mux_chk.sv
// Assertion checker for tx_char_mux, attached with bind.
// Watches the handoff between the slow pipeline and the fast selector.
// Assumes the same LANES as the design.
module tx_char_mux_chk
    import tx_mux_pkg::*;
#(
    parameter int LANES = 4
) (
    input logic                      clk_fast,
    input logic                      rst_n,
    input logic                      load,
    input logic [$clog2(LANES)-1:0]  phase,
    input logic [LANES*CHAR_W-1:0]   word,
    input logic [CHAR_W-1:0]         char_out
);
    localparam int GW = $clog2(LANES) + 1;

    logic [GW-1:0] gap;
    logic          seen;

    // Count fast cycles since the last load, saturating at LANES.
    always_ff @(posedge clk_fast) begin
        if (!rst_n) begin
            gap  <= '0;
            seen <= 1'b0;
        end else if (load) begin
            gap  <= '0;
            seen <= 1'b1;
        end else if (gap != GW'(LANES)) begin
            gap  <= gap + 1'b1;
        end
    end

    // R7: after the first load, loads come exactly one slow period apart.
    a_r7_load_spacing: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (seen && load) |-> (gap == GW'(LANES - 1)));

    // R7: the phase counter restarts at 1 after each load.
    a_r7_phase_restart: assert property (@(posedge clk_fast) disable iff (!rst_n)
        load |=> (phase == 1));

    // R3: the word from the slow pipeline holds still except where a load takes it.
    a_r3_word_steady: assert property (@(posedge clk_fast) disable iff (!rst_n)
        !load |-> $stable(word));

    // R5: the first cycle out of reset still shows an all-zero character.
    a_r5_zero_after_reset: assert property (@(posedge clk_fast) disable iff (!rst_n)
        !$past(rst_n) |-> (char_out == '0));
endmodule

bind tx_char_mux tx_char_mux_chk #(.LANES(LANES)) u_chk (
    .clk_fast (clk_fast),
    .rst_n    (rst_n),
    .load     (load),
    .phase    (phase),
    .word     (word),
    .char_out (char_out)
);

// File: tb/tb_tx_char_mux.sv
// Self-checking bench for tx_char_mux, with a behavioural reference queue.
module tb_tx_char_mux;
    logic        clk_fast = 1'b0;
    logic        clk_slow = 1'b0;
    logic        rst_n    = 1'b0;
    logic [31:0] tx_data    = '0;
    logic [3:0]  tx_special = '0;
    logic [3:0]  tx_neg     = '0;
    logic [9:0]  char_out;

    int n_pos = 0;   // number of fast rising edges so far
    int checks = 0;
    int fails  = 0;
    int k0 = -1;     // fast index of the first capture since reset
    int wc = 0;      // words generated
    logic [39:0] words [$];
    logic [39:0] cur = '0;

    tx_char_mux dut (
        .clk_fast   (clk_fast),
        .clk_slow   (clk_slow),
        .rst_n      (rst_n),
        .tx_data    (tx_data),
        .tx_special (tx_special),
        .tx_neg     (tx_neg),
        .char_out   (char_out)
    );

    // 50 MHz fast clock; the slow clock rises with every fourth fast edge.
    initial begin
        forever begin
            #10;
            clk_fast = 1'b1;
            if (n_pos % 4 == 0)      clk_slow = 1'b1;
            else if (n_pos % 4 == 2) clk_slow = 1'b0;
            n_pos = n_pos + 1;
            #10;
            clk_fast = 1'b0;
        end
    end

    function automatic logic [9:0] lane_char(logic [39:0] w, int lane);
        return {w[36+lane], w[32+lane], w[lane*8 +: 8]};
    endfunction

    function automatic logic [39:0] next_word(int idx);
        case (idx)
            0: return {4'hF, 4'hF, 32'hFFFF_FFFF};
            1: return {4'h0, 4'hF, 32'h0000_0000};
            2: return {4'hF, 4'h0, 32'h0000_0000};
            3: return {4'b0101, 4'b1010, 32'h1122_3344};
            default: return {$urandom(), $urandom()};
        endcase
    endfunction

    task automatic apply(logic [39:0] w);
        tx_neg     = w[39:36];
        tx_special = w[35:32];
        tx_data    = w[31:0];
    endtask

    // One fast cycle: update the model, check the output, drive the inputs.
    task automatic step();
        int p;
        int d;
        logic [9:0] exp_c;
        string tag;
        @(negedge clk_fast);
        p = n_pos - 1;
        if (!rst_n) begin
            words.delete();
            k0 = -1;
        end else if (p % 4 == 0) begin
            if (k0 < 0) k0 = p;
            words.push_back(cur);
        end
        exp_c = '0;
        tag = !rst_n ? "R5" : "R5,R6";
        if (rst_n && k0 >= 0) begin
            d = p - 13 - k0;
            if (d >= 0 && d / 4 < words.size()) begin
                // R1 bit layout, R2 lane order, R3 latency, R4 back-to-back,
                // R7 one pickup per slow period, R8 off-edge changes ignored
                exp_c = lane_char(words[d / 4], 3 - d % 4);
                tag = "R1,R2,R3,R4,R7,R8";
            end
        end
        checks++;
        if (char_out !== exp_c) begin
            fails++;
            $display("FAIL %s at fast edge %0d: char_out=%h expected=%h", tag, p, char_out, exp_c);
        end
        if (p % 4 == 0) begin
            cur = next_word(wc);
            wc++;
            apply(cur);
        end else if (p % 4 == 2) begin
            apply(~cur);          // R8: garbage between slow edges
        end else if (p % 4 == 3) begin
            apply(cur);
        end
    endtask

    initial begin
        #4000000;
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int r = 0; r < 4; r++) begin
            rst_n = 1'b0;              // R5, R6: reset, mid-stream after the first pass
            repeat (10) step();
            while ((n_pos - 1) % 4 != r) step();
            rst_n = 1'b1;              // R6: release at fast offset r
            repeat (120 + 37 * r) step();
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule